// File: doc/BRIEF.md
# Time-Slot Channel Assigner

This block assigns the bit positions of a TDM frame to logical HDLC channels. A command memory holds one 16-bit entry for each time slot. Each entry gives the channel number, an eight-bit mask of the slot bits that belong to the channel, and three control flags: half-rate, direct serial routing and contention-bus enable. A free-running position counter walks through the frame one bit per clock. A frame sync pulse realigns the counter, and a frame parity tracks even and odd frames. For every bit, the block outputs the current slot's channel number, receive and transmit bit strobes, the routed receive data bit, the direct serial output bit and an active-low pull-down for an open-drain contention line.

Software reaches the memory through a two-register control port. It first writes an address word: bits 4:0 select the slot, and bit 15 selects the access (1 = read, 0 = write). A write access then takes one data word, which is stored in that slot. A read access returns the entry on the read-data port. In half-rate mode a slot carries its data once per pair of frames. In the even frame, transmit bits are requested and recorded. In the odd frame the recorded bits are replayed, and no strobes are raised in either direction.

Top module: `tsa_assigner`

## Requirements
- R1: After reset every entry is zero, the read-data port is zero, both strobes are low, the channel output is zero and the contention pull-down is inactive (high).
- R2: The position advances one bit per clock: eight bits per slot (bit 0 first) and 32 slots per frame, wrapping to slot 0. A cycle with frame sync high makes the next cycle slot 0 bit 0.
- R3: An address write with bit 15 = 0 arms a write. The next data write stores the data word in the addressed slot and disarms. A data write while not armed changes no entry.
- R4: An address write with bit 15 = 1 places the addressed entry on the read-data port after the second rising edge following the write. The port holds that value until the next read.
- R5: The channel output equals entry bits 4:0 of the slot at the current position.
- R6: Entry bit 5+k enables the receive and transmit strobes on bit k of the slot. With the bit clear, both strobes stay low.
- R7: Entry bit 13 selects half-rate. Frame parity is even after reset and flips at every frame start (wrap or frame sync). In half-rate slots the strobes are raised only in even frames.
- R8: In an odd frame, a half-rate slot's transmit data for bit k is the transmit input sampled on bit k of that slot in the preceding even frame.
- R9: Entry bit 14 set: the receive data output follows the direct serial input, and the direct serial output carries the transmit data on masked bits and 1 on unmasked bits. Bit 14 clear: the receive data output follows the matrix input, and the direct serial output follows the matrix output input.
- R10: With entry bit 15 set and the CSMA mode input low, the pull-down is active (low) exactly on masked bits whose transmit data is 0. With entry bit 15 clear, it stays high.
- R11: While the CSMA mode input is high, the contention flag has no effect and the pull-down stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync: the next cycle is slot 0 bit 0 |
| csma_mode | input | 1 | Global CSMA mode, overrides the contention flag |
| cfg_wr | input | 1 | Control-port write strobe |
| cfg_sel | input | 1 | 0 = address register, 1 = data register |
| cfg_wdata | input | 16 | Control-port write data |
| cfg_rdata | output | 16 | Entry returned by a read access |
| rx_din_direct | input | 1 | Dedicated serial receive input |
| rx_din_matrix | input | 1 | Receive data from the switching matrix |
| rx_bit | output | 1 | Routed receive bit to the receive engine |
| rx_valid | output | 1 | Receive bit strobe |
| tx_bit | input | 1 | Transmit bit from the transmit engine |
| tx_valid | output | 1 | Transmit bit request strobe |
| mtx_dout | input | 1 | Matrix output passed to the direct serial output |
| tx_dout_direct | output | 1 | Dedicated serial output |
| ch_id | output | 5 | Channel number of the current slot |
| cb_pull_n | output | 1 | Contention line pull-down enable, active low |

## Verification
All per-bit outputs are combinational from the registered position and the stored entry. They are due in the same cycle as the position, and the bench samples them at the falling edge, after the rising edge that moved the position. An entry write becomes visible one cycle after the edge that samples the data word. Read data is due after the second rising edge that follows the address write, so the read check waits one extra rising edge before sampling at the falling edge. The behavioural model updates its position, parity, replay bits and memory at each rising edge from the inputs that were driven 2 ns after the previous edge, and it compares every output at every falling edge.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int SUB_N = 8;
    localparam int SUB_W = $clog2(SUB_N);
    localparam int CH_W  = 5;
    localparam int CFG_W = 16;

    typedef struct packed {
        logic             cbus;
        logic             direct;
        logic             half;
        logic [SUB_N-1:0] mask;
        logic [CH_W-1:0]  ch;
    } tsa_entry_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_ARMED,
        CP_FETCH
    } cp_state_t;

    typedef enum logic {
        PH_EVEN,
        PH_ODD
    } phase_t;
endpackage

// File: rtl/tsa_frame_timer.sv
module tsa_frame_timer
    import tsa_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fsync,
    output logic [$clog2(N_SLOTS)-1:0] slot_o,
    output logic [SUB_W-1:0]           bit_o,
    output logic                       par_o
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
    localparam logic [SUB_W-1:0]  LAST_BIT  = SUB_W'(SUB_N - 1);

    phase_t phase_q, phase_d;
    logic [SLOT_W-1:0] slot_q;
    logic [SUB_W-1:0]  bit_q;
    logic              end_of_slot;
    logic              frame_start;

    // phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_EVEN;
        else        phase_q <= phase_d;
    end

    always_comb begin
        end_of_slot = (bit_q == LAST_BIT);
        frame_start = fsync || (end_of_slot && slot_q == LAST_SLOT);
        phase_d     = phase_q;
        if (frame_start) begin
            unique case (phase_q)
                PH_EVEN: phase_d = PH_ODD;
                PH_ODD:  phase_d = PH_EVEN;
                default: phase_d = PH_EVEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (fsync) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (end_of_slot) begin
            bit_q  <= '0;
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    always_comb begin
        slot_o = slot_q;
        bit_o  = bit_q;
        par_o  = (phase_q == PH_ODD);
    end
endmodule

// File: rtl/tsa_cmd_mem.sv
module tsa_cmd_mem
    import tsa_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       cfg_sel,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic [$clog2(N_SLOTS)-1:0] cur_slot,
    output tsa_entry_t                 cur_entry,
    output logic [CFG_W-1:0]           cfg_rdata
);
    localparam int SLOT_W = $clog2(N_SLOTS);

    cp_state_t   state_q, state_d;
    logic [SLOT_W-1:0] addr_q;
    tsa_entry_t  mem_q [N_SLOTS];
    tsa_entry_t  rdata_q;
    logic        addr_load;
    logic        data_wr;
    logic        commit;
    logic        fetch;

    // control-port state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        addr_load = cfg_wr && !cfg_sel;
        data_wr   = cfg_wr && cfg_sel;
        state_d   = state_q;
        if (addr_load) begin
            state_d = cfg_wdata[CFG_W-1] ? CP_FETCH : CP_ARMED;
        end else begin
            unique case (state_q)
                CP_IDLE:  state_d = CP_IDLE;
                CP_ARMED: if (data_wr) state_d = CP_IDLE;
                CP_FETCH: state_d = CP_IDLE;
                default:  state_d = CP_IDLE;
            endcase
        end
        commit = data_wr && (state_q == CP_ARMED);
        fetch  = (state_q == CP_FETCH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         addr_q <= '0;
        else if (addr_load) addr_q <= cfg_wdata[SLOT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) mem_q[i] <= '0;
        end else if (commit) begin
            mem_q[addr_q] <= tsa_entry_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (fetch) rdata_q <= mem_q[addr_q];
    end

    always_comb begin
        cur_entry = mem_q[cur_slot];
        cfg_rdata = rdata_q;
    end
endmodule

// File: rtl/tsa_bit_router.sv
module tsa_bit_router
    import tsa_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  tsa_entry_t                 entry,
    input  logic [$clog2(N_SLOTS)-1:0] slot_i,
    input  logic [SUB_W-1:0]           bit_i,
    input  logic                       par_i,
    input  logic                       csma_mode,
    input  logic                       rx_din_direct,
    input  logic                       rx_din_matrix,
    input  logic                       tx_bit,
    input  logic                       mtx_dout,
    output logic [CH_W-1:0]            ch_id,
    output logic                       rx_bit,
    output logic                       rx_valid,
    output logic                       tx_valid,
    output logic                       tx_dout_direct,
    output logic                       cb_pull_n
);
    logic [SUB_N-1:0] replay_q [N_SLOTS];
    logic             bit_sel;
    logic             active;
    logic             replay;
    logic             tx_eff;

    always_comb begin
        bit_sel = entry.mask[bit_i];
        active  = bit_sel && (!entry.half || !par_i);
        replay  = entry.half && par_i;
        tx_eff  = replay ? replay_q[slot_i][bit_i] : tx_bit;
    end

    // even-frame capture of half-rate transmit bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) replay_q[i] <= '0;
        end else if (entry.half && !par_i && bit_sel) begin
            replay_q[slot_i][bit_i] <= tx_bit;
        end
    end

    always_comb begin
        ch_id          = entry.ch;
        rx_valid       = active;
        tx_valid       = active;
        rx_bit         = entry.direct ? rx_din_direct : rx_din_matrix;
        tx_dout_direct = entry.direct ? (bit_sel ? tx_eff : 1'b1) : mtx_dout;
        cb_pull_n      = !(entry.cbus && !csma_mode && bit_sel && !tx_eff);
    end
endmodule

// File: rtl/tsa_assigner.sv
module tsa_assigner
    import tsa_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             csma_mode,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic             rx_din_direct,
    input  logic             rx_din_matrix,
    output logic             rx_bit,
    output logic             rx_valid,
    input  logic             tx_bit,
    output logic             tx_valid,
    input  logic             mtx_dout,
    output logic             tx_dout_direct,
    output logic [4:0]       ch_id,
    output logic             cb_pull_n
);
    localparam int SLOT_W = $clog2(N_SLOTS);

    tsa_entry_t        cur_entry;
    logic [SLOT_W-1:0] cur_slot;
    logic [SUB_W-1:0]  cur_bit;
    logic              cur_par;

    tsa_frame_timer #(.N_SLOTS(N_SLOTS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fsync  (fsync),
        .slot_o (cur_slot),
        .bit_o  (cur_bit),
        .par_o  (cur_par)
    );

    tsa_cmd_mem #(.N_SLOTS(N_SLOTS)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cur_slot  (cur_slot),
        .cur_entry (cur_entry),
        .cfg_rdata (cfg_rdata)
    );

    tsa_bit_router #(.N_SLOTS(N_SLOTS)) u_route (
        .clk            (clk),
        .rst_n          (rst_n),
        .entry          (cur_entry),
        .slot_i         (cur_slot),
        .bit_i          (cur_bit),
        .par_i          (cur_par),
        .csma_mode      (csma_mode),
        .rx_din_direct  (rx_din_direct),
        .rx_din_matrix  (rx_din_matrix),
        .tx_bit         (tx_bit),
        .mtx_dout       (mtx_dout),
        .ch_id          (ch_id),
        .rx_bit         (rx_bit),
        .rx_valid       (rx_valid),
        .tx_valid       (tx_valid),
        .tx_dout_direct (tx_dout_direct),
        .cb_pull_n      (cb_pull_n)
    );
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
    import tsa_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fsync,
    input logic                       csma_mode,
    input tsa_entry_t                 cur_entry,
    input logic [$clog2(N_SLOTS)-1:0] cur_slot,
    input logic [SUB_W-1:0]           cur_bit,
    input logic                       cur_par,
    input logic                       rx_valid,
    input logic                       tx_valid,
    input logic                       cb_pull_n
);
    AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cur_slot == '0 && cur_bit == '0)); // R2
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && cur_bit != SUB_W'(SUB_N - 1)) |=> (cur_bit == $past(cur_bit) + 1'b1)); // R2
    AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_entry.mask[cur_bit] |-> (!rx_valid && !tx_valid)); // R6
    AST_HALF_ODD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_entry.half && cur_par) |-> (!rx_valid && !tx_valid)); // R7
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cur_par != $past(cur_par))); // R7
    AST_CB_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_entry.cbus |-> cb_pull_n); // R10
    AST_CSMA_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        csma_mode |-> cb_pull_n); // R11
endmodule

bind tsa_assigner tsa_checker #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .csma_mode (csma_mode),
    .cur_entry (cur_entry),
    .cur_slot  (cur_slot),
    .cur_bit   (cur_bit),
    .cur_par   (cur_par),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .cb_pull_n (cb_pull_n)
);

// File: tb/sim_tsa_assigner.sv
`timescale 1ns/1ps
module sim_tsa_assigner;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        csma_mode = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rx_din_direct = 1'b0;
    logic        rx_din_matrix = 1'b0;
    logic        rx_bit, rx_valid, tx_valid, tx_dout_direct, cb_pull_n;
    logic        tx_bit = 1'b0;
    logic        mtx_dout = 1'b0;
    logic [4:0]  ch_id;

    tsa_assigner u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .csma_mode(csma_mode),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_din_direct(rx_din_direct), .rx_din_matrix(rx_din_matrix),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .mtx_dout(mtx_dout), .tx_dout_direct(tx_dout_direct),
        .ch_id(ch_id), .cb_pull_n(cb_pull_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int cb_low_seen = 0;
    bit chk_on  = 1'b0;

    // behavioural reference state
    logic [15:0] m_mem [32];
    logic        m_store [32][8];
    int          m_slot, m_bit, m_addr;
    bit          m_par, m_armed, m_fetch;
    logic [15:0] m_rdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                m_mem[i] = '0;
                for (int k = 0; k < 8; k++) m_store[i][k] = 1'b0;
            end
            m_slot = 0; m_bit = 0; m_par = 0;
            m_addr = 0; m_armed = 0; m_fetch = 0; m_rdata = '0;
        end else begin
            logic [15:0] e;
            e = m_mem[m_slot];
            if (e[13] && !m_par && e[5 + m_bit]) m_store[m_slot][m_bit] = tx_bit;
            if (m_fetch) m_rdata = m_mem[m_addr];
            if (cfg_wr && !cfg_sel) begin
                m_addr  = int'(cfg_wdata[4:0]);
                m_fetch = cfg_wdata[15];
                m_armed = !cfg_wdata[15];
            end else if (cfg_wr && cfg_sel && m_armed) begin
                m_mem[m_addr] = cfg_wdata;
                m_armed = 0;
                m_fetch = 0;
            end else begin
                m_fetch = 0;
            end
            if (fsync) begin
                m_slot = 0; m_bit = 0; m_par = !m_par;
            end else if (m_bit == 7) begin
                m_bit = 0;
                if (m_slot == 31) begin
                    m_slot = 0; m_par = !m_par;
                end else begin
                    m_slot++;
                end
            end else begin
                m_bit++;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            logic [15:0] e;
            bit mb, act, txo, exp_dout, exp_cb;
            e   = m_mem[m_slot];
            mb  = e[5 + m_bit];
            act = mb && (!e[13] || !m_par);
            txo = (e[13] && m_par) ? m_store[m_slot][m_bit] : tx_bit;
            exp_dout = e[14] ? (mb ? txo : 1'b1) : mtx_dout;
            exp_cb   = !(e[15] && !csma_mode && mb && !txo);
            if (!cb_pull_n) cb_low_seen++;
            chk(ch_id == e[4:0], "R5", "ch_id", ch_id, e[4:0]);
            chk(rx_valid == act, e[13] ? "R7" : "R6", "rx_valid", rx_valid, act);
            chk(tx_valid == act, e[13] ? "R7" : "R6", "tx_valid", tx_valid, act);
            chk(rx_bit == (e[14] ? rx_din_direct : rx_din_matrix), "R9", "rx_bit",
                rx_bit, e[14] ? rx_din_direct : rx_din_matrix);
            chk(tx_dout_direct == exp_dout, (e[13] && m_par && e[14]) ? "R8" : "R9",
                "tx_dout_direct", tx_dout_direct, exp_dout);
            chk(cb_pull_n == exp_cb, csma_mode ? "R11" : "R10", "cb_pull_n",
                cb_pull_n, exp_cb);
            chk(cfg_rdata == m_rdata, "R4", "cfg_rdata", cfg_rdata, m_rdata);
        end
    end

    // random data inputs, changed 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        rx_din_direct <= 1'($urandom);
        rx_din_matrix <= 1'($urandom);
        tx_bit        <= 1'($urandom);
        mtx_dout      <= 1'($urandom);
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic cfg_write(input bit sel, input logic [15:0] data);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic wr_entry(input int slot, input logic [15:0] data);
        cfg_write(1'b0, 16'(slot));
        cfg_write(1'b1, data);
    endtask

    task automatic rd_check(input int slot, input logic [15:0] exp, input string req);
        cfg_write(1'b0, 16'h8000 | 16'(slot));
        @(posedge clk);
        @(negedge clk);
        chk(cfg_rdata == exp, req, "read-back", cfg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ch_id == 5'd0, "R1", "ch_id", ch_id, 0);
        chk(!rx_valid && !tx_valid, "R1", "strobes", {rx_valid, tx_valid}, 0);
        chk(cb_pull_n == 1'b1, "R1", "cb_pull_n", cb_pull_n, 1);
        chk(cfg_rdata == 16'h0, "R1", "cfg_rdata", cfg_rdata, 0);
        chk_on = 1'b1;

        wr_entry(0, 16'h5FE3);   // ch 3, all bits, direct
        wr_entry(1, 16'hF4B1);   // ch 17, mask A5, half, direct, contention
        wr_entry(2, 16'h81FF);   // ch 31, mask 0F, contention
        wr_entry(5, 16'h3029);   // ch 9, mask 81, half
        // R3: unarmed data write must not land anywhere
        cfg_write(1'b1, 16'hFFFF);
        rd_check(5, 16'h3029, "R3");
        rd_check(1, 16'hF4B1, "R4");
        rd_check(7, 16'h0000, "R1");

        // R2: frame sync realigns to slot 0 bit 0
        @(posedge clk); #2 fsync = 1'b1;
        @(posedge clk); #2 fsync = 1'b0;
        @(negedge clk);
        chk(ch_id == 5'd3, "R2", "ch after fsync", ch_id, 3);
        chk(rx_valid == 1'b1, "R6", "slot0 bit0 strobe", rx_valid, 1);
        repeat (8) @(negedge clk);
        chk(ch_id == 5'd17, "R2", "ch at slot 1", ch_id, 17);

        repeat (1024) @(posedge clk);
        // mid-frame resync
        #2 fsync = 1'b1;
        @(posedge clk); #2 fsync = 1'b0;
        repeat (600) @(posedge clk);
        chk(cb_low_seen > 0, "R10", "pull-down activity", cb_low_seen, 1);

        // R11: contention flag ignored under CSMA mode
        #2 csma_mode = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(cb_pull_n == 1'b1, "R11", "cb_pull_n under csma", cb_pull_n, 1);
        end
        @(posedge clk); #2 csma_mode = 1'b0;
        repeat (520) @(posedge clk);

        @(negedge clk);
        chk_on = 1'b0;
        summary();
        $finish;
    end
endmodule